// File: doc/BRIEF.md
# Bufferless Deflection Mesh Router

A single router for a two-dimensional mesh network on chip that has no flit storage at all. Four neighbour links (north, east, south, west) and a local inject/eject pair all meet in one pass. Every flit that is accepted in a cycle is placed on some output one cycle later. When several flits want the same link, the oldest gets it. The others are pushed onto whatever neighbour link is still free, even if that link takes them away from their destination. Giving the oldest flit priority guarantees that a flit bounced around the mesh eventually wins and cannot circle forever.

The work is split into two stages. The first stage computes each flit's preferred direction and its priority rank, increments its age and stores the result in a pipeline register that resets to empty. The second stage reads that register and hands out ports in rank order. A flit offered by the local node is taken only when fewer than four neighbour flits arrive in the same cycle. This keeps the number of flits in flight no larger than the number of neighbour links, so a deflection target always exists.

Top module: `defl_router`

## Requirements
- R1: A flit accepted on a neighbour input, or injected with `inj_ack` high, appears exactly once on the outputs in the following cycle. No flit is dropped or duplicated, including under back-to-back traffic.
- R2: The flit layout has destination X in bits [X_W-1:0], destination Y in the next Y_W bits, age in the next AGE_W bits and payload in the top PAY_W bits. Each departing flit leaves with its age one higher than on arrival, saturating at the maximum (255 for 8 bits).
- R3: `inj_ack` equals `inj_vld` when at most three of `nb_in_vld` are set. It is 0 when all four are set.
- R4: The preferred port follows dimension order. If destination X is above the router's X, the flit goes east (index 1). If it is below, the flit goes west (index 3). Only when the X values are equal is Y used: a larger Y goes north (index 0) and a smaller Y goes south (index 2). When both X and Y match, the flit goes to the eject port.
- R5: Among contending flits, the larger age wins. On equal age, the lower slot index wins, with neighbours in slots 0 to 3 by port index and the injected flit in slot 4.
- R6: Flits are served in priority order. A flit whose preferred port is already taken is placed on the lowest-index neighbour port still free.
- R7: At most one flit leaves on the eject port per cycle, and only a flit addressed to this router. Further local flits are deflected as in R6.
- R8: During reset and in the first cycle after it, all outputs are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nb_in_vld | input | 4 | Valid per neighbour input (N=0, E=1, S=2, W=3) |
| nb_in_flit | input | 4*FW | Neighbour input flits, port p in bits [p*FW +: FW] |
| inj_vld | input | 1 | Local node offers a flit |
| inj_flit | input | FW | Flit offered by the local node |
| inj_ack | output | 1 | Offered flit is taken this cycle |
| nb_out_vld | output | 4 | Valid per neighbour output |
| nb_out_flit | output | 4*FW | Neighbour output flits, port p in bits [p*FW +: FW] |
| ej_vld | output | 1 | Flit delivered to the local node |
| ej_flit | output | FW | Delivered flit |

## Verification
The hardest condition to reach is a full router: four neighbour flits and a waiting injection in the same cycle, all wanting the same link. In that cycle injection must be refused and three of the four flits must be deflected onto the ports left over in rank order. A directed task builds exactly this case with distinct ages, so every port assignment is predictable. A second case gives two local flits to test eject contention, and equal-age pairs test the tie rule. A back-to-back stream then steps through all sixteen neighbour-valid patterns with an injection offered every cycle. After each cycle it confirms that every tagged payload appears exactly once.

// File: rtl/defl_router.sv
`timescale 1ns/1ps
module defl_router #(
  parameter int X_W   = 3,
  parameter int Y_W   = 3,
  parameter int AGE_W = 8,
  parameter int PAY_W = 16,
  parameter int MY_X  = 2,
  parameter int MY_Y  = 2,
  localparam int FW   = X_W + Y_W + AGE_W + PAY_W,
  localparam int NS   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      nb_in_vld,
  input  logic [4*FW-1:0] nb_in_flit,
  input  logic            inj_vld,
  input  logic [FW-1:0]   inj_flit,
  output logic            inj_ack,
  output logic [3:0]      nb_out_vld,
  output logic [4*FW-1:0] nb_out_flit,
  output logic            ej_vld,
  output logic [FW-1:0]   ej_flit
);
  localparam int AGE_LO = X_W + Y_W;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  function automatic logic [2:0] route(input logic [FW-1:0] f);
    logic [X_W-1:0] dx;
    logic [Y_W-1:0] dy;
    dx = f[X_W-1:0];
    dy = f[X_W +: Y_W];
    if (dx > X_W'(MY_X))      return 3'd1;
    else if (dx < X_W'(MY_X)) return 3'd3;
    else if (dy > Y_W'(MY_Y)) return 3'd0;
    else if (dy < Y_W'(MY_Y)) return 3'd2;
    else                      return 3'd4;
  endfunction

  assign inj_ack = inj_vld & ~(&nb_in_vld);

  logic [NS-1:0]    sv;
  logic [FW-1:0]    sf   [NS];
  logic [AGE_W-1:0] sage [NS];
  logic [2:0]       srank[NS];

  for (genvar p = 0; p < 4; p++) begin : g_in
    assign sv[p] = nb_in_vld[p];
    assign sf[p] = nb_in_flit[p*FW +: FW];
  end
  assign sv[4] = inj_ack;
  assign sf[4] = inj_flit;

  for (genvar s = 0; s < NS; s++) begin : g_age
    assign sage[s] = sf[s][AGE_LO +: AGE_W];
  end

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      srank[s] = 3'd0;
      for (int o = 0; o < NS; o++)
        if (o != s && sv[o] && (sage[o] > sage[s] || (sage[o] == sage[s] && o < s)))
          srank[s] = srank[s] + 3'd1;
    end
  end

  logic [NS-1:0] pv;
  logic [FW-1:0] pf [NS];
  logic [2:0]    pr [NS];
  logic [2:0]    pd [NS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= '0;
    else        pv <= sv;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NS; s++) begin
      pf[s] <= sf[s];
      if (sage[s] != AGE_MAX) pf[s][AGE_LO +: AGE_W] <= sage[s] + 1'b1;
      pr[s] <= srank[s];
      pd[s] <= route(sf[s]);
    end
  end

  logic [NS-1:0] taken;
  logic [NS-1:0] ov;
  logic [FW-1:0] of [NS];
  logic [2:0]    port;
  logic          hit;

  always_comb begin
    taken = '0;
    ov    = '0;
    port  = 3'd0;
    hit   = 1'b0;
    for (int p = 0; p < NS; p++) of[p] = '0;
    for (int r = 0; r < NS; r++) begin
      for (int s = 0; s < NS; s++) begin
        if (pv[s] && pr[s] == 3'(r)) begin
          port = pd[s];
          if (taken[pd[s]]) begin
            hit = 1'b0;
            for (int p = 0; p < 4; p++)
              if (!hit && !taken[p]) begin
                port = 3'(p);
                hit  = 1'b1;
              end
          end
          taken[port] = 1'b1;
          ov[port]    = 1'b1;
          of[port]    = pf[s];
        end
      end
    end
  end

  for (genvar p = 0; p < 4; p++) begin : g_out
    assign nb_out_vld[p]           = ov[p];
    assign nb_out_flit[p*FW +: FW] = of[p];
  end
  assign ej_vld  = ov[4];
  assign ej_flit = of[4];
endmodule

module defl_router_chk #(
  parameter int X_W  = 3,
  parameter int Y_W  = 3,
  parameter int FW   = 30,
  parameter int MY_X = 2,
  parameter int MY_Y = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    nb_in_vld,
  input logic          inj_vld,
  input logic          inj_ack,
  input logic [3:0]    nb_out_vld,
  input logic          ej_vld,
  input logic [FW-1:0] ej_flit
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_conserve_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ($countones({nb_out_vld, ej_vld}) ==
               $past($countones(nb_in_vld)) + $past(int'(inj_ack))));

  p_inj_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&nb_in_vld) |-> !inj_ack);

  p_inj_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_vld && !(&nb_in_vld)) |-> inj_ack);

  p_eject_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ej_vld |-> (ej_flit[X_W-1:0] == X_W'(MY_X) && ej_flit[X_W +: Y_W] == Y_W'(MY_Y)));

  p_idle_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> ({nb_out_vld, ej_vld} == 5'd0));
endmodule

bind defl_router defl_router_chk #(
  .X_W(X_W), .Y_W(Y_W), .FW(FW), .MY_X(MY_X), .MY_Y(MY_Y)
) chk_i (
  .clk(clk), .rst_n(rst_n), .nb_in_vld(nb_in_vld), .inj_vld(inj_vld),
  .inj_ack(inj_ack), .nb_out_vld(nb_out_vld), .ej_vld(ej_vld), .ej_flit(ej_flit)
);

// File: tb/defl_router_tb_top.sv
`timescale 1ns/1ps
module defl_router_tb_top;
  localparam int X_W = 3, Y_W = 3, AGE_W = 8, PAY_W = 16;
  localparam int FW = X_W + Y_W + AGE_W + PAY_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      nv = '0;
  logic [FW-1:0]   nin [4];
  logic [4*FW-1:0] nb_in_flit;
  logic            iv = 1'b0;
  logic [FW-1:0]   ifl = '0;
  logic            inj_ack;
  logic [3:0]      nb_out_vld;
  logic [4*FW-1:0] nb_out_flit;
  logic            ej_vld;
  logic [FW-1:0]   ej_flit;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  for (genvar p = 0; p < 4; p++) begin : g_pack
    assign nb_in_flit[p*FW +: FW] = nin[p];
  end

  defl_router dut_i (
    .clk(clk), .rst_n(rst_n), .nb_in_vld(nv), .nb_in_flit(nb_in_flit),
    .inj_vld(iv), .inj_flit(ifl), .inj_ack(inj_ack),
    .nb_out_vld(nb_out_vld), .nb_out_flit(nb_out_flit),
    .ej_vld(ej_vld), .ej_flit(ej_flit)
  );

  function automatic logic [FW-1:0] mk(int x, int y, int age, int pay);
    return {PAY_W'(pay), AGE_W'(age), Y_W'(y), X_W'(x)};
  endfunction

  function automatic logic [FW-1:0] outf(int p);
    return nb_out_flit[p*FW +: FW];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in;
    nv = '0; iv = 1'b0; ifl = '0;
    for (int p = 0; p < 4; p++) nin[p] = '0;
  endtask

  task automatic step_out;
    @(negedge clk);
    clear_in();
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset;
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({nb_out_vld, ej_vld} == 5'd0, "R8 outputs during reset", {nb_out_vld, ej_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({nb_out_vld, ej_vld} == 5'd0, "R8 outputs first cycle after reset", {nb_out_vld, ej_vld}, 0);
  endtask

  task automatic t_single(input int x, input int y, input int age, input int exp_port, input int exp_age);
    @(negedge clk);
    clear_in();
    nv[3] = 1'b1; nin[3] = mk(x, y, age, 16'h1000 + exp_port);
    step_out();
    if (exp_port == 4) begin
      chk(ej_vld && nb_out_vld == 4'd0, "R4 route to eject", {nb_out_vld, ej_vld}, 1);
      chk(ej_flit == mk(x, y, exp_age, 16'h1004), "R2 ejected flit/age", ej_flit, mk(x, y, exp_age, 16'h1004));
    end else begin
      chk(nb_out_vld == 4'(1 << exp_port) && !ej_vld, "R4 route direction", {nb_out_vld, ej_vld}, 4'(1 << exp_port) << 1);
      chk(outf(exp_port) == mk(x, y, exp_age, 16'h1000 + exp_port), "R2 forwarded flit/age",
          outf(exp_port), mk(x, y, exp_age, 16'h1000 + exp_port));
    end
  endtask

  task automatic t_contend_age;
    @(negedge clk);
    clear_in();
    nv = 4'b0101;
    nin[0] = mk(3, 2, 3, 16'hA0);
    nin[2] = mk(3, 2, 7, 16'hA2);
    step_out();
    chk(outf(1) == mk(3, 2, 8, 16'hA2), "R5 older flit wins east", outf(1), mk(3, 2, 8, 16'hA2));
    chk(outf(0) == mk(3, 2, 4, 16'hA0), "R6 loser deflected to north", outf(0), mk(3, 2, 4, 16'hA0));
    chk(nb_out_vld == 4'b0011, "R6 port set", nb_out_vld, 4'b0011);
  endtask

  task automatic t_contend_tie;
    @(negedge clk);
    clear_in();
    nv = 4'b1001;
    nin[0] = mk(3, 2, 4, 16'hB0);
    nin[3] = mk(3, 2, 4, 16'hB3);
    step_out();
    chk(outf(1) == mk(3, 2, 5, 16'hB0), "R5 tie lower slot wins", outf(1), mk(3, 2, 5, 16'hB0));
    chk(outf(0) == mk(3, 2, 5, 16'hB3), "R6 tie loser deflected", outf(0), mk(3, 2, 5, 16'hB3));
  endtask

  task automatic t_eject_contend;
    @(negedge clk);
    clear_in();
    nv = 4'b0110;
    nin[1] = mk(2, 2, 1, 16'hC1);
    nin[2] = mk(2, 2, 9, 16'hC2);
    step_out();
    chk(ej_vld && ej_flit == mk(2, 2, 10, 16'hC2), "R7 older local flit ejected", ej_flit, mk(2, 2, 10, 16'hC2));
    chk(nb_out_vld == 4'b0001 && outf(0) == mk(2, 2, 2, 16'hC1), "R7 second local flit deflected",
        outf(0), mk(2, 2, 2, 16'hC1));
  endtask

  task automatic t_full;
    @(negedge clk);
    clear_in();
    nv = 4'b1111;
    nin[0] = mk(3, 2, 10, 16'hD0);
    nin[1] = mk(3, 2, 20, 16'hD1);
    nin[2] = mk(3, 2, 30, 16'hD2);
    nin[3] = mk(3, 2, 40, 16'hD3);
    iv = 1'b1; ifl = mk(3, 2, 99, 16'hD4);
    #1;
    chk(inj_ack == 1'b0, "R3 inject refused when full", inj_ack, 0);
    step_out();
    chk(nb_out_vld == 4'b1111 && !ej_vld, "R1 four flits out", {nb_out_vld, ej_vld}, 5'b11110);
    chk(outf(1) == mk(3, 2, 41, 16'hD3), "R5 oldest of four wins", outf(1), mk(3, 2, 41, 16'hD3));
    chk(outf(0) == mk(3, 2, 31, 16'hD2), "R6 second deflected north", outf(0), mk(3, 2, 31, 16'hD2));
    chk(outf(2) == mk(3, 2, 21, 16'hD1), "R6 third deflected south", outf(2), mk(3, 2, 21, 16'hD1));
    chk(outf(3) == mk(3, 2, 11, 16'hD0), "R6 youngest deflected west", outf(3), mk(3, 2, 11, 16'hD0));
  endtask

  task automatic t_inject;
    @(negedge clk);
    clear_in();
    nv = 4'b0111;
    nin[0] = mk(1, 2, 1, 16'hE0);
    nin[1] = mk(1, 2, 2, 16'hE1);
    nin[2] = mk(1, 2, 3, 16'hE2);
    iv = 1'b1; ifl = mk(1, 2, 50, 16'hE4);
    #1;
    chk(inj_ack == 1'b1, "R3 inject accepted with free link", inj_ack, 1);
    step_out();
    chk(outf(3) == mk(1, 2, 51, 16'hE4), "R5 old injected flit wins west", outf(3), mk(1, 2, 51, 16'hE4));
    chk(outf(0) == mk(1, 2, 4, 16'hE2), "R6 deflect order 1", outf(0), mk(1, 2, 4, 16'hE2));
    chk(outf(1) == mk(1, 2, 3, 16'hE1), "R6 deflect order 2", outf(1), mk(1, 2, 3, 16'hE1));
    chk(outf(2) == mk(1, 2, 2, 16'hE0), "R6 deflect order 3", outf(2), mk(1, 2, 2, 16'hE0));
  endtask

  task automatic t_stream;
    logic [PAY_W-1:0] sent [5];
    logic [4:0]       sv;
    sv = '0;
    for (int i = 0; i <= 32; i++) begin
      @(negedge clk);
      if (i > 0) begin
        int tot;
        tot = 0;
        for (int s = 0; s < 5; s++) begin
          if (sv[s]) begin
            int hits;
            hits = 0;
            tot++;
            for (int p = 0; p < 4; p++)
              if (nb_out_vld[p] && outf(p)[FW-1 -: PAY_W] == sent[s]) hits++;
            if (ej_vld && ej_flit[FW-1 -: PAY_W] == sent[s]) hits++;
            chk(hits == 1, "R1 payload seen once", hits, 1);
          end
        end
        chk($countones({nb_out_vld, ej_vld}) == tot, "R1 output count", $countones({nb_out_vld, ej_vld}), tot);
      end
      clear_in();
      sv = '0;
      if (i < 32) begin
        nv = 4'(i % 16);
        for (int p = 0; p < 4; p++) begin
          sent[p] = PAY_W'(16'h5000 + i * 8 + p);
          nin[p]  = mk((i + p) % 5, (i * 3 + p) % 5, (i * 37 + p * 91) % 256, sent[p]);
        end
        sent[4] = PAY_W'(16'h5000 + i * 8 + 4);
        iv  = 1'b1;
        ifl = mk((i * 2) % 5, (i + 1) % 5, (i * 53) % 256, sent[4]);
        #1;
        chk(inj_ack == (nv != 4'hF), "R3 inject grant in stream", inj_ack, nv != 4'hF);
        sv = {inj_ack, nv};
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    clear_in();
    t_reset();
    t_single(3, 2, 5, 1, 6);
    t_single(1, 2, 5, 3, 6);
    t_single(2, 3, 5, 0, 6);
    t_single(2, 1, 5, 2, 6);
    t_single(3, 0, 5, 1, 6);
    t_single(2, 2, 5, 4, 6);
    t_single(3, 2, 255, 1, 255);
    t_contend_age();
    t_contend_tie();
    t_eject_contend();
    t_full();
    t_inject();
    t_stream();
    summary();
  end
endmodule